// File: doc/BRIEF.md
# Dual-Channel Bit-Compare Error Counter

This block measures the disagreement rate between two digital samples of one received serial signal. Two slicers see the same line and share one recovered clock; one is held at a reference point while the other is moved around the eye. The block lines the two bit streams up for a programmable relative skew, compares them bit by bit, and counts the mismatches over a measurement window counted in valid bit periods. Error count divided by bits compared gives a figure equivalent to a bit-error rate at the scanning channel's position.

Software or a scan sequencer picks a skew, picks which channel is delayed, writes a window length and pulses start. When the window has been filled, a one-cycle done pulse is raised. The error and bit counts then stay frozen until the next start or clear. Windows shorter than 65,536 bits are raised to that minimum. A nonzero count from two channels at the same operating point is a real result and is reported unchanged.

Top module: `bcc_err_counter`

## Requirements
- R1: After synchronous active-low reset, err_count and bit_count are 0, done is 0 and no measurement is running.
- R2: Each channel keeps the last 7 bits it presented with bit_valid high. The delayed channel (scan when delay_scan is 1, reference when delay_scan is 0) is compared using the bit it presented skew_amt valid bits earlier, or the present bit when skew_amt is 0. The other channel always uses its present bit. History is 0 after reset.
- R3: During a measurement, every counted bit whose two aligned values differ adds one to err_count. Equal bits add nothing.
- R4: A cycle with bit_valid low compares nothing, leaves bit_count and err_count unchanged and does not advance either channel's history.
- R5: start latches the window as win_len, or as 65,536 when win_len is smaller. bit_count rises by one per counted bit and stops at the latched window.
- R6: done is high for exactly the one cycle after the bit that fills the window. From then on, both counts hold until start or clear.
- R7: err_count saturates at its all-ones value (ERR_W bits) and never wraps.
- R8: clear zeroes both counts, drops done and stops any measurement. It wins over a start in the same cycle.
- R9: start zeroes both counts and begins a new measurement, even while one is running. No bit is counted in the start cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock for both channels |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new measurement (one-cycle pulse) |
| clear | input | 1 | Abort and zero the counts |
| bit_valid | input | 1 | Both channel bits are valid this cycle |
| ref_bit | input | 1 | Reference channel sample |
| scan_bit | input | 1 | Scanning channel sample |
| skew_amt | input | SKEW_W (3) | Relative skew in valid bits, 0 to 7 |
| delay_scan | input | 1 | 1 delays the scan channel, 0 delays the reference |
| win_len | input | WIN_W (32) | Requested window in bit periods |
| err_count | output | ERR_W (32) | Saturating mismatch count |
| bit_count | output | WIN_W (32) | Bits compared in the present window |
| done | output | 1 | One-cycle pulse when the window is filled |

## Verification
Each counted bit updates err_count and bit_count at the next rising edge. done rises at that same edge for the bit that fills the window, and the effects of clear and start are visible one edge after the cycle they are driven in. The bench drives inputs on the falling edge. Its queue-based model is updated right after the rising edge, and the counts, a second narrow-counter instance and done are compared at the following falling edge, so every result is checked in the cycle it is due. Long windows check the 65,536 minimum and a longer programmed window. Known injected flips on a skewed copy of the reference check the alignment.

// File: rtl/bcc_pkg.sv
// Shared definitions for the bit-compare error counter.
// Assumes: one clock domain for both channels and the counters.
package bcc_pkg;
    // Smallest window the counter will measure, in bit periods.
    localparam int unsigned MIN_WINDOW = 65536;

    // Measurement controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bcc_state_e;
endpackage

// File: rtl/bcc_skew_align.sv
// Skew alignment for the two sample channels.
// Each channel keeps a short history of its valid bits. One channel,
// selected by delay_scan, is tapped skew_amt valid bits back and the
// other is passed through. Assumes skew_amt stays within MAX_SKEW;
// larger values select the present bit.
module bcc_skew_align #(
    parameter int MAX_SKEW = 7,
    parameter int SKEW_W   = $clog2(MAX_SKEW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              ref_bit,
    input  logic              scan_bit,
    input  logic [SKEW_W-1:0] skew_amt,
    input  logic              delay_scan,
    output logic              ref_al,
    output logic              scan_al
);
    localparam int NCH = 2;

    logic [NCH-1:0] ch_in;
    logic [NCH-1:0] ch_tap;

    assign ch_in = {scan_bit, ref_bit};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [MAX_SKEW-1:0] hist;

        // Shift the channel's history on every valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist <= '0;
            end else if (bit_valid) begin
                hist <= {hist[MAX_SKEW-2:0], ch_in[g]};
            end
        end

        // Select the bit presented skew_amt valid bits ago.
        always_comb begin
            ch_tap[g] = ch_in[g];
            for (int k = 1; k <= MAX_SKEW; k++) begin
                if (skew_amt == SKEW_W'(k)) begin
                    ch_tap[g] = hist[k-1];
                end
            end
        end
    end

    // Apply the delay to the selected channel only.
    always_comb begin
        ref_al  = delay_scan ? ch_in[0]  : ch_tap[0];
        scan_al = delay_scan ? ch_tap[1] : ch_in[1];
    end
endmodule

// File: rtl/bcc_window_ctrl.sv
// Measurement window controller.
// Latches the effective window at start, counts compared bits and
// issues a one-cycle done when the window is filled. Assumes
// WIN_W is wide enough to hold MIN_WINDOW.
module bcc_window_ctrl #(
    parameter int WIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clear,
    input  logic             bit_valid,
    input  logic [WIN_W-1:0] win_len,
    output logic             count_en,
    output logic [WIN_W-1:0] bit_count,
    output logic             done
);
    import bcc_pkg::*;

    localparam logic [WIN_W-1:0] MIN_WIN = WIN_W'(MIN_WINDOW);

    bcc_state_e       state;
    logic [WIN_W-1:0] win_q;
    logic             last_bit;

    // A bit counts only in a running window and outside control cycles.
    assign count_en = (state == ST_RUN) && bit_valid && !start && !clear;
    assign last_bit = count_en && (bit_count == win_q - 1'b1);

    // Controller state, latched window, bit counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            win_q     <= MIN_WIN;
            bit_count <= '0;
            done      <= 1'b0;
        end else if (clear) begin
            state     <= ST_IDLE;
            bit_count <= '0;
            done      <= 1'b0;
        end else if (start) begin
            state     <= ST_RUN;
            win_q     <= (win_len < MIN_WIN) ? MIN_WIN : win_len;
            bit_count <= '0;
            done      <= 1'b0;
        end else begin
            done <= last_bit;
            if (count_en) begin
                bit_count <= bit_count + 1'b1;
            end
            if (last_bit) begin
                state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/bcc_mismatch_accum.sv
// Saturating mismatch accumulator.
// Adds one per counted mismatch and sticks at all-ones. Assumes
// zero_cnt is asserted for start and clear.
module bcc_mismatch_accum #(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_cnt,
    input  logic             hit,
    output logic [ERR_W-1:0] err_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    // Count mismatches without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_count <= '0;
        end else if (zero_cnt) begin
            err_count <= '0;
        end else if (hit && (err_count != ERR_MAX)) begin
            err_count <= err_count + 1'b1;
        end
    end
endmodule

// File: rtl/bcc_err_counter.sv
// Dual-channel bit-compare error counter, top level.
// Aligns two sample streams of one input, compares them bit by bit
// and counts mismatches over a window of valid bit periods.
// Assumes both samples are timed by clk and arrive together.
module bcc_err_counter #(
    parameter int MAX_SKEW = 7,
    parameter int SKEW_W   = $clog2(MAX_SKEW + 1),
    parameter int ERR_W    = 32,
    parameter int WIN_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clear,
    input  logic              bit_valid,
    input  logic              ref_bit,
    input  logic              scan_bit,
    input  logic [SKEW_W-1:0] skew_amt,
    input  logic              delay_scan,
    input  logic [WIN_W-1:0]  win_len,
    output logic [ERR_W-1:0]  err_count,
    output logic [WIN_W-1:0]  bit_count,
    output logic              done
);
    logic ref_al;
    logic scan_al;
    logic count_en;
    logic hit;

    bcc_skew_align #(
        .MAX_SKEW (MAX_SKEW),
        .SKEW_W   (SKEW_W)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .ref_bit    (ref_bit),
        .scan_bit   (scan_bit),
        .skew_amt   (skew_amt),
        .delay_scan (delay_scan),
        .ref_al     (ref_al),
        .scan_al    (scan_al)
    );

    bcc_window_ctrl #(
        .WIN_W (WIN_W)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear     (clear),
        .bit_valid (bit_valid),
        .win_len   (win_len),
        .count_en  (count_en),
        .bit_count (bit_count),
        .done      (done)
    );

    // A mismatch on a counted bit is one error.
    assign hit = count_en && (ref_al ^ scan_al);

    bcc_mismatch_accum #(
        .ERR_W (ERR_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_cnt  (start | clear),
        .hit       (hit),
        .err_count (err_count)
    );
endmodule

// File: rtl/bcc_err_counter_chk.sv
// Property checker for the bit-compare error counter, bound to the top.
// Observes ports only.
module bcc_err_counter_chk #(
    parameter int ERR_W = 32,
    parameter int WIN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             clear,
    input logic             bit_valid,
    input logic [ERR_W-1:0] err_count,
    input logic [WIN_W-1:0] bit_count,
    input logic             done
);
    // R6
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_min_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (64'(bit_count) >= 64'(bcc_pkg::MIN_WINDOW)));

    // R4
    idle_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !start && !clear) |=> ($stable(bit_count) && $stable(err_count)));

    // R7
    err_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !clear) |=> (err_count >= $past(err_count)));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bit_count == '0 && err_count == '0 && !done));

    // R3
    err_within_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        64'(err_count) <= 64'(bit_count));
endmodule

bind bcc_err_counter bcc_err_counter_chk #(
    .ERR_W (ERR_W),
    .WIN_W (WIN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .clear     (clear),
    .bit_valid (bit_valid),
    .err_count (err_count),
    .bit_count (bit_count),
    .done      (done)
);

// File: tb/bcc_err_counter_bench.sv
module bcc_err_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MINW       = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, clear = 1'b0, bit_valid = 1'b0;
    logic        ref_bit = 1'b0, scan_bit = 1'b0;
    logic [2:0]  skew_amt = 3'd0;
    logic        delay_scan = 1'b0;
    logic [31:0] win_len = 32'd0;
    logic [31:0] err_count, bit_count;
    logic [7:0]  err_small;
    logic [31:0] bit_small;
    logic        done, done_small;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model state
    longint m_err, m_err8, m_bits, m_win;
    bit     m_run, m_done;
    bit     rq[$], sq[$];
    int     flips;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcc_err_counter u_bcc_err_counter (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
        .bit_valid(bit_valid), .ref_bit(ref_bit), .scan_bit(scan_bit),
        .skew_amt(skew_amt), .delay_scan(delay_scan), .win_len(win_len),
        .err_count(err_count), .bit_count(bit_count), .done(done)
    );

    bcc_err_counter #(.ERR_W(8)) u_bcc_err_counter_sat (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
        .bit_valid(bit_valid), .ref_bit(ref_bit), .scan_bit(scan_bit),
        .skew_amt(skew_amt), .delay_scan(delay_scan), .win_len(win_len),
        .err_count(err_small), .bit_count(bit_small), .done(done_small)
    );

    function automatic void chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_err = 0; m_err8 = 0; m_bits = 0; m_win = MINW;
        m_run = 0; m_done = 0;
        rq.delete(); sq.delete();
        for (int i = 0; i < 7; i++) begin
            rq.push_back(1'b0);
            sq.push_back(1'b0);
        end
    endfunction

    // One clock: drive at the falling edge, model after the rising edge, check at the next falling edge.
    task automatic cyc(bit v, bit r, bit s, bit st, bit cl);
        bit rd, sd, mism;
        bit_valid = v; ref_bit = r; scan_bit = s; start = st; clear = cl;
        @(posedge clk);
        rd = r; sd = s;
        if (skew_amt != 0) begin
            if (delay_scan) sd = sq[skew_amt-1];
            else            rd = rq[skew_amt-1];
        end
        mism = (rd != sd);
        if (cl) begin
            m_err = 0; m_err8 = 0; m_bits = 0; m_run = 0; m_done = 0;
        end else if (st) begin
            m_err = 0; m_err8 = 0; m_bits = 0; m_run = 1; m_done = 0;
            m_win = (win_len < MINW) ? MINW : win_len;
        end else begin
            m_done = 0;
            if (m_run && v) begin
                m_bits++;
                if (mism) begin
                    if (m_err < 64'hFFFF_FFFF) m_err++;
                    if (m_err8 < 255) m_err8++;
                end
                if (m_bits == m_win) begin
                    m_done = 1; m_run = 0;
                end
            end
        end
        if (v) begin
            rq.push_front(r); void'(rq.pop_back());
            sq.push_front(s); void'(sq.pop_back());
        end
        @(negedge clk);
        chk("R3 err_count", err_count, m_err);
        chk("R7 saturating err_count", err_small, m_err8);
        chk("R4 bit_count", bit_count, m_bits);
        chk("R6 done", done, m_done);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 err_count", err_count, 0);
        chk("R1 bit_count", bit_count, 0);
        chk("R1 done", done, 0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 idle bit_count", bit_count, 0);

        // R2/R5: scan is the reference delayed 5 bits plus known flips; short win_len raised to minimum
        skew_amt = 3'd5; delay_scan = 1'b0; win_len = 32'd5;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        flips = 0;
        while (!m_done) begin
            bit v, r, f, s;
            v = ($urandom % 10) != 0;
            r = $urandom[0];
            f = ($urandom % 64) == 0;
            s = v ? (rq[4] ^ f) : $urandom[0];
            if (v && f && m_run) flips++;
            cyc(v, r, s, 1'b0, 1'b0);
        end
        chk("R5 window raised to minimum", bit_count, MINW);
        chk("R2 aligned errors equal injected flips", err_count, flips);
        for (int i = 0; i < 5; i++) cyc(1'b1, $urandom[0], $urandom[0], 1'b0, 1'b0);
        chk("R6 count held after done", bit_count, MINW);
        chk("R6 errors held after done", err_count, flips);

        // R8: clear wins over start
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R8 bit_count zero", bit_count, 0);
        chk("R8 err_count zero", err_count, 0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 stopped, no counting", bit_count, 0);

        // R2 with maximum skew on the scan side, then R9 restart with zero skew
        skew_amt = 3'd7; delay_scan = 1'b1; win_len = 32'd0;
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 300; i++) cyc(($urandom % 4) != 0, $urandom[0], $urandom[0], 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R9 restart zeroes bit_count", bit_count, 0);
        chk("R9 restart zeroes err_count", err_count, 0);
        skew_amt = 3'd0;
        for (int i = 0; i < 200; i++) begin
            bit r;
            r = $urandom[0];
            cyc(1'b1, r, (i % 3 == 0) ? ~r : r, 1'b0, 1'b0);
        end
        chk("R3 one error per mismatch", err_count, 67);

        // R5/R7: longer programmed window with uncorrelated channels
        skew_amt = 3'd2; delay_scan = 1'b1; win_len = 32'd70000;
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        while (!m_done) cyc(1'b1, $urandom[0], $urandom[0], 1'b0, 1'b0);
        chk("R5 programmed window", bit_count, 70000);
        chk("R7 narrow counter saturated", err_small, 255);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8 clear after done", err_count, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule